// File: doc/BRIEF.md
# Read-After-Write Stall Unit

This block decides, every cycle, whether the instruction in decode must wait because a source register it reads is still being produced by an older instruction in flight. It watches the decode instruction's two source register numbers and their read enables. It also keeps a short shift record of the destination register, write enable and load flag of each older instruction. When a true read-after-write conflict falls inside the hazard window, it raises `stall`. That signal freezes fetch and decode, and a bubble with write enable low is pushed into the record in place of the held instruction.

The hazard window is fixed at elaboration by two parameters. `NUM_STAGES` selects a classic 5-stage pipeline or a 6-stage pipeline in which the memory access spans two stages. `FWD_EN` states whether results are bypassed. With bypassing, only loads can cause a conflict, and only at short range. Without it, any writer within a few slots conflicts. The stall drops on its own once the producer has moved far enough ahead, so a conflict at distance d costs (window + 1 - d) cycles.

Top module: `raw_stall_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it, the record holds only bubbles, so a decode instruction reading any register sees `stall` low.
- R2: A later instruction that writes a register an older one reads (write after read), or that writes the same register (write after write), never raises `stall` unless it also reads a register that is pending.
- R3: With 5 stages and bypassing on, a load followed directly by a reader of its destination costs exactly one stall cycle. A reader two or more slots behind the load costs none, and a non-load producer never stalls.
- R4: With 5 stages and bypassing off, a reader at distance d = 1, 2 or 3 behind any writer of its source stalls for 4 - d cycles. At distance 4 or more it does not stall.
- R5: With 6 stages and bypassing on, a reader at distance 1 or 2 behind a load stalls for 3 - d cycles. Non-load producers and loads at distance 3 or more cause no stall.
- R6: With 6 stages and bypassing off, a reader at distance d = 1 to 4 behind any writer stalls for 5 - d cycles. At distance 5 it does not stall.
- R7: A producer whose destination is register 0, or whose write enable is low, never causes a stall.
- R8: A source whose read enable is low is never compared, and an instruction with both read enables low never stalls.
- R9: While `stall` is high, the next record slot receives a bubble (write enable low) instead of the decode instruction. When `stall` is low, it receives the decode instruction's destination, write enable and load flag. Older slots shift by one each cycle.
- R10: Both source ports are checked: a match on either the first or the second source alone raises the stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low; clears the record to bubbles |
| decRs1 | input | 5 | First source register number of the decode instruction |
| decRs1En | input | 1 | First source is read |
| decRs2 | input | 5 | Second source register number of the decode instruction |
| decRs2En | input | 1 | Second source is read |
| decRd | input | 5 | Destination register number of the decode instruction |
| decWe | input | 1 | Decode instruction writes its destination |
| decIsLoad | input | 1 | Decode instruction is a load |
| stall | output | 1 | Hold fetch and decode and insert a bubble this cycle |

## Verification
The hardest situation to reach is a multi-cycle stall that must shrink by exactly one cycle for each slot of distance. This happens when the producer sits at the far edge of a 3- or 4-slot window behind filler instructions, and the bubbles the block inserts itself must not add stall cycles. The stimulus builds, for each of the four configurations, a producer followed by d - 1 non-conflicting fillers and then a reader, for d from 1 to 5, with both a load and an ALU producer. The bench holds each instruction until `stall` drops and compares the total stall cycles with an issue-time model computed from the window size. Further sequences cover the four-instruction load chain, write-after-read and write-after-write pairs, register 0, disabled writes and disabled reads.

// File: rtl/raw_stall_pkg.sv
package raw_stall_pkg;

  localparam int REG_W = 5;

  // One tracked older instruction; an all-zero entry is a bubble.
  typedef struct packed {
    logic [REG_W-1:0] rd;
    logic             we;
    logic             isLoad;
  } slot_t;

  // Strobes from the control half to the record half.
  typedef struct packed {
    logic hold;
    logic bubble;
  } strobe_t;

  // Slots that must be watched: with bypassing only load results are late
  // (by one stage per memory stage); without it every writer is late until
  // its write-back has been seen by decode.
  function automatic int trackDepth(int numStages, bit fwdEn);
    return fwdEn ? (numStages - 4) : (numStages - 2);
  endfunction

endpackage

// File: rtl/raw_stall_track.sv
module raw_stall_track
  import raw_stall_pkg::*;
#(
  parameter int DEPTH = 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                strobes,
  input  logic [REG_W-1:0]       decRd,
  input  logic                   decWe,
  input  logic                   decIsLoad,
  output slot_t [DEPTH-1:0]      recQ
);

  slot_t incoming;

  always_comb begin
    if (strobes.bubble) begin
      incoming = '0;
    end else begin
      incoming.rd     = decRd;
      incoming.we     = decWe;
      incoming.isLoad = decIsLoad;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) recQ[0] <= '0;
    else       recQ[0] <= incoming;
  end

  for (genvar k = 1; k < DEPTH; k++) begin : g_shift
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) recQ[k] <= '0;
      else       recQ[k] <= recQ[k-1];
    end
  end

endmodule

// File: rtl/raw_stall_ctrl.sv
module raw_stall_ctrl
  import raw_stall_pkg::*;
#(
  parameter int DEPTH  = 1,
  parameter bit FWD_EN = 1'b1
) (
  input  slot_t [DEPTH-1:0]   recQ,
  input  logic [REG_W-1:0]    decRs1,
  input  logic                decRs1En,
  input  logic [REG_W-1:0]    decRs2,
  input  logic                decRs2En,
  output strobe_t             strobes
);

  logic [DEPTH-1:0] slotHit;

  for (genvar k = 0; k < DEPTH; k++) begin : g_cmp
    logic writes;
    logic srcMatch;
    logic late;

    assign writes   = recQ[k].we && (recQ[k].rd != '0);
    assign srcMatch = (decRs1En && (decRs1 == recQ[k].rd)) ||
                      (decRs2En && (decRs2 == recQ[k].rd));

    if (FWD_EN) begin : g_fwd
      assign late = recQ[k].isLoad;
    end else begin : g_nofwd
      assign late = 1'b1;
    end

    assign slotHit[k] = writes && late && srcMatch;
  end

  always_comb begin
    strobes.hold   = |slotHit;
    strobes.bubble = |slotHit;
  end

endmodule

// File: rtl/raw_stall_unit.sv
module raw_stall_unit
  import raw_stall_pkg::*;
#(
  parameter int NUM_STAGES = 5,
  parameter bit FWD_EN     = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [REG_W-1:0] decRs1,
  input  logic             decRs1En,
  input  logic [REG_W-1:0] decRs2,
  input  logic             decRs2En,
  input  logic [REG_W-1:0] decRd,
  input  logic             decWe,
  input  logic             decIsLoad,
  output logic             stall
);

  localparam int DEPTH = trackDepth(NUM_STAGES, FWD_EN);

  slot_t [DEPTH-1:0] trackQ;
  strobe_t           strobes;

  raw_stall_ctrl #(.DEPTH(DEPTH), .FWD_EN(FWD_EN)) ctrl_i (
    .recQ     (trackQ),
    .decRs1   (decRs1),
    .decRs1En (decRs1En),
    .decRs2   (decRs2),
    .decRs2En (decRs2En),
    .strobes  (strobes)
  );

  raw_stall_track #(.DEPTH(DEPTH)) track_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .decRd     (decRd),
    .decWe     (decWe),
    .decIsLoad (decIsLoad),
    .recQ      (trackQ)
  );

  assign stall = strobes.hold;

endmodule

// File: rtl/raw_stall_unit_chk.sv
module raw_stall_unit_chk
  import raw_stall_pkg::*;
#(
  parameter int NUM_STAGES = 5,
  parameter bit FWD_EN     = 1'b1
) (
  input logic                                          clk,
  input logic                                          rstN,
  input logic [REG_W-1:0]                              decRs1,
  input logic                                          decRs1En,
  input logic [REG_W-1:0]                              decRs2,
  input logic                                          decRs2En,
  input logic [REG_W-1:0]                              decRd,
  input logic                                          decWe,
  input logic                                          decIsLoad,
  input logic                                          stall,
  input slot_t [trackDepth(NUM_STAGES, FWD_EN)-1:0]    rec
);

  localparam int DEPTH = trackDepth(NUM_STAGES, FWD_EN);

  logic liveWriter;
  always_comb begin
    liveWriter = 1'b0;
    for (int k = 0; k < DEPTH; k++)
      liveWriter = liveWriter | (rec[k].we && (rec[k].rd != '0));
  end

  // R9: a stall pushes a bubble into the first slot
  p_bubble_on_stall_r9: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> !rec[0].we);

  // R9: without a stall the decode instruction is captured
  p_capture_r9: assert property (@(posedge clk) disable iff (!rstN)
    !stall |=> (rec[0].rd == $past(decRd)) && (rec[0].we == $past(decWe)) &&
               (rec[0].isLoad == $past(decIsLoad)));

  for (genvar k = 1; k < DEPTH; k++) begin : g_shift_chk
    // R9: older slots move one step per cycle
    p_shift_r9: assert property (@(posedge clk) disable iff (!rstN)
      $past(rstN) |-> rec[k] == $past(rec[k-1]));
  end

  // R8: no read means no stall
  p_no_read_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!decRs1En && !decRs2En) |-> !stall);

  // R7: no live writer in the record means no stall
  p_no_writer_r7: assert property (@(posedge clk) disable iff (!rstN)
    !liveWriter |-> !stall);

  // R3: a load directly ahead of a reader of its result always stalls
  p_load_use_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rec[0].we && rec[0].isLoad && (rec[0].rd != '0) &&
     decRs1En && (decRs1 == rec[0].rd)) |-> stall);

endmodule

bind raw_stall_unit raw_stall_unit_chk #(
  .NUM_STAGES (NUM_STAGES),
  .FWD_EN     (FWD_EN)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .decRs1    (decRs1),
  .decRs1En  (decRs1En),
  .decRs2    (decRs2),
  .decRs2En  (decRs2En),
  .decRd     (decRd),
  .decWe     (decWe),
  .decIsLoad (decIsLoad),
  .stall     (stall),
  .rec       (trackQ)
);

// File: tb/raw_stall_unit_tb_top.sv
`timescale 1ns/100ps
module raw_stall_unit_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic [4:0] rs1V [4];
  logic       e1V  [4];
  logic [4:0] rs2V [4];
  logic       e2V  [4];
  logic [4:0] rdV  [4];
  logic       weV  [4];
  logic       ldV  [4];
  logic       stallV [4];

  for (genvar c = 0; c < 4; c++) begin : g_cfg
    raw_stall_unit #(
      .NUM_STAGES ((c < 2) ? 5 : 6),
      .FWD_EN     ((c % 2) == 0)
    ) dut_i (
      .clk (clk), .rstN (rstN),
      .decRs1 (rs1V[c]), .decRs1En (e1V[c]),
      .decRs2 (rs2V[c]), .decRs2En (e2V[c]),
      .decRd (rdV[c]), .decWe (weV[c]), .decIsLoad (ldV[c]),
      .stall (stallV[c])
    );
  end

  int errors = 0;
  int checks = 0;

  // sequence storage
  logic [4:0] sRd [8];
  logic       sWe [8];
  logic       sLd [8];
  logic [4:0] sRs1 [8];
  logic       sE1 [8];
  logic [4:0] sRs2 [8];
  logic       sE2 [8];

  task automatic setI(int i, int rd, bit we, bit ld, int r1, bit e1, int r2, bit e2);
    sRd[i] = 5'(rd); sWe[i] = we; sLd[i] = ld;
    sRs1[i] = 5'(r1); sE1[i] = e1; sRs2[i] = 5'(r2); sE2[i] = e2;
  endtask

  function automatic string cfgTag(int c);
    case (c)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic int window(int c);
    case (c)
      0: return 1;
      1: return 3;
      2: return 2;
      default: return 4;
    endcase
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic idle(int c);
    rs1V[c] = '0; e1V[c] = 1'b0; rs2V[c] = '0; e2V[c] = 1'b0;
    rdV[c] = '0; weV[c] = 1'b0; ldV[c] = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    for (int c = 0; c < 4; c++) idle(c);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // Issue-time model: each instruction issues one slot after its predecessor,
  // or later if a conflicting producer is still inside the window.
  function automatic int modelStalls(int c, int n);
    int t [8];
    int w;
    bit loadOnly;
    w = window(c);
    loadOnly = (c % 2) == 0;
    for (int i = 0; i < n; i++) begin
      t[i] = (i == 0) ? 0 : t[i-1] + 1;
      for (int j = 0; j < i; j++) begin
        if (sWe[j] && sRd[j] != 5'd0 && (!loadOnly || sLd[j]) &&
            ((sE1[i] && sRs1[i] == sRd[j]) || (sE2[i] && sRs2[i] == sRd[j])))
          if (t[j] + w + 1 > t[i]) t[i] = t[j] + w + 1;
      end
    end
    return t[n-1] - (n - 1);
  endfunction

  task automatic runSeq(int c, int n, string tag, string what);
    int i;
    int stalls;
    int guard;
    int expStalls;
    expStalls = modelStalls(c, n);
    doReset();
    i = 0; stalls = 0; guard = 0;
    while (i < n && guard < 100) begin
      @(negedge clk);
      rs1V[c] = sRs1[i]; e1V[c] = sE1[i]; rs2V[c] = sRs2[i]; e2V[c] = sE2[i];
      rdV[c] = sRd[i]; weV[c] = sWe[i]; ldV[c] = sLd[i];
      #1;
      if (stallV[c]) stalls++;
      else i++;
      guard++;
    end
    @(negedge clk);
    idle(c);
    check(tag, what, stalls, expStalls);
  endtask

  // producer at distance d ahead of a reader; fillers touch other registers
  task automatic buildDist(int d, bit ld, bit useSrc2);
    setI(0, 5, 1'b1, ld, 1, 1'b1, 0, 1'b0);
    for (int k = 1; k < d; k++) setI(k, 10 + k, 1'b1, 1'b0, 2, 1'b1, 3, 1'b1);
    if (useSrc2) setI(d, 20, 1'b1, 1'b0, 4, 1'b1, 5, 1'b1);
    else         setI(d, 20, 1'b1, 1'b0, 5, 1'b1, 4, 1'b1);
  endtask

  initial begin
    for (int c = 0; c < 4; c++) idle(c);

    // R1: stall stays low during and right after reset with readers present
    for (int c = 0; c < 4; c++) begin
      rs1V[c] = 5'd9; e1V[c] = 1'b1; rs2V[c] = 5'd9; e2V[c] = 1'b1;
    end
    repeat (2) @(negedge clk);
    check("R1", "stall in reset cfg0", int'(stallV[0]), 0);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    for (int c = 0; c < 4; c++) check("R1", "stall after reset", int'(stallV[c]), 0);

    for (int c = 0; c < 4; c++) begin
      // distance sweep, load and ALU producers, both source ports (R10)
      for (int d = 1; d <= 5; d++) begin
        buildDist(d, 1'b1, d[0]);
        runSeq(c, d + 1, cfgTag(c), $sformatf("load producer distance %0d", d));
        buildDist(d, 1'b0, ~d[0]);
        runSeq(c, d + 1, cfgTag(c), $sformatf("alu producer distance %0d", d));
      end

      // R10: second source alone matches a load directly ahead
      setI(0, 6, 1'b1, 1'b1, 1, 1'b1, 0, 1'b0);
      setI(1, 7, 1'b1, 1'b0, 2, 1'b1, 6, 1'b1);
      runSeq(c, 2, "R10", "second source match");

      // R3/R5 chain: add r1<-r2,r1; lw r2<-(r1); lw r1<-(r1); or r3<-r1,r2
      setI(0, 1, 1'b1, 1'b0, 2, 1'b1, 1, 1'b1);
      setI(1, 2, 1'b1, 1'b1, 1, 1'b1, 0, 1'b0);
      setI(2, 1, 1'b1, 1'b1, 1, 1'b1, 0, 1'b0);
      setI(3, 3, 1'b1, 1'b0, 1, 1'b1, 2, 1'b1);
      runSeq(c, 4, cfgTag(c), "four instruction load chain");

      // R2: write after read and write after write do not stall
      setI(0, 7, 1'b1, 1'b1, 8, 1'b1, 0, 1'b0);
      setI(1, 8, 1'b1, 1'b1, 9, 1'b1, 0, 1'b0);
      setI(2, 7, 1'b1, 1'b0, 9, 1'b0, 11, 1'b1);
      runSeq(c, 3, "R2", "war and waw pair");
      check("R2", "war/waw stall cycles", modelStalls(c, 3), 0);

      // R7: destination register 0 from a load
      setI(0, 0, 1'b1, 1'b1, 1, 1'b1, 0, 1'b0);
      setI(1, 4, 1'b1, 1'b0, 0, 1'b1, 0, 1'b1);
      runSeq(c, 2, "R7", "register 0 producer");

      // R7: write enable low
      setI(0, 6, 1'b0, 1'b1, 1, 1'b1, 0, 1'b0);
      setI(1, 4, 1'b1, 1'b0, 6, 1'b1, 6, 1'b1);
      runSeq(c, 2, "R7", "write enable low producer");

      // R8: matching register numbers with read enables low
      setI(0, 6, 1'b1, 1'b1, 1, 1'b1, 0, 1'b0);
      setI(1, 4, 1'b1, 1'b0, 6, 1'b0, 6, 1'b0);
      runSeq(c, 2, "R8", "read enables low");

      // R9: back-to-back loads with a reader of both, self bubbles add nothing
      setI(0, 12, 1'b1, 1'b1, 1, 1'b1, 0, 1'b0);
      setI(1, 13, 1'b1, 1'b1, 12, 1'b1, 0, 1'b0);
      setI(2, 14, 1'b1, 1'b0, 12, 1'b1, 13, 1'b1);
      runSeq(c, 3, "R9", "stall release with bubbles");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule